// File: doc/BRIEF.md
# DMA Transfer Counter with Shadow Reload

This block keeps the byte count for a storage controller's DMA transfers. Software programs the count one byte at a time into write-only shadow bytes. A separate live counter is what reads return and what the transfer consumes. When a command is issued with its DMA flag set, the live counter is reloaded from the shadow bytes. A DMA transfer command then waits for the external DMA enable. Once enabled, the block works out how many bytes will move and counts them down as the data path accepts each one.

At the end of a transfer the block sets the terminal-count flag, zeroes the live count and pulses `done`. Neighbouring logic uses that pulse to raise the interrupt and to set the interrupt-reason and sequence-step registers. Until software first writes the top count byte, reads of that byte return a fixed chip identifier instead of the live value. The bus-phase logic and the DMA engine are outside this block.

Top module: `dma_tcount`

## Requirements
- R1: The live count is built from byte registers selected by `wr_sel`/`rd_sel`. Select 0 is bits 7:0, select 1 is bits 15:8 and select 2 is bits 23:16. `rd_data` returns the selected live byte, and selects above 2 read as zero.
- R2: A `cmd_wr` with `cmd_dma`=1 copies the shadow bytes into the live count and sets `dma_mode` on the next clock. A `cmd_wr` with `cmd_dma`=0 clears `dma_mode` and leaves the live count unchanged.
- R3: Writing a shadow byte does not change the live count.
- R4: A write to any count byte clears `tc` on the next clock, unless a transfer finishes on that same clock.
- R5: A read with select 2 returns the constant `CHIP_ID` (default 8'h3C) until a write with select 2 has occurred after reset. After that, it returns the live high byte.
- R6: A `cmd_wr` with `cmd_dma`=1 and `cmd_xfer`=1, issued while idle, sets `pending`. The command stays pending while `dma_en` is low. It starts once, on the first clock on which `dma_en` is high. A transfer command with `cmd_dma`=0 has no effect on `pending` or `busy`.
- R7: At start, a live count of zero is taken as 65536 bytes.
- R8: The transfer length is the smaller of the effective count and the magnitude of the signed `data_left`. A negative value means data flows toward the device. The length appears on `remaining` one clock after the start.
- R9: Starting a transfer clears `tc` and sets `busy` on that same clock edge.
- R10: Each `byte_ack` while `busy` lowers `remaining` by one and lowers the live count by one, saturating at zero. A `byte_ack` while not busy changes nothing.
- R11: The acknowledge that brings `remaining` to zero ends the transfer. On the next clock `busy` is low, `tc` is set, all live count bytes are zero, and `done` is high for exactly one cycle.
- R12: A start whose computed length is zero completes at once, with the same outcome as R11 and without `busy` ever rising.
- R13: After reset, `tc`, `busy`, `pending`, `dma_mode`, `done`, `remaining` and the live count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a count shadow byte |
| wr_sel | input | 2 | Byte select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Byte select for reads |
| rd_data | output | 8 | Live count byte or chip identifier |
| cmd_wr | input | 1 | Command issue strobe |
| cmd_dma | input | 1 | DMA flag of the issued command |
| cmd_xfer | input | 1 | Issued command is a transfer command |
| data_left | input | 25 | Signed remaining data size; negative toward device |
| dma_en | input | 1 | External DMA enable |
| byte_ack | input | 1 | One byte accepted by the data path |
| live_count | output | 24 | Live transfer count |
| remaining | output | 24 | Bytes left in the current transfer |
| pending | output | 1 | Transfer command waiting for DMA enable |
| busy | output | 1 | Transfer in progress |
| dma_mode | output | 1 | Last command carried the DMA flag |
| tc | output | 1 | Terminal count reached |
| done | output | 1 | One-cycle transfer completion pulse |

## Verification
The assertions assume a few things about the inputs. Commands are not issued while a transfer is pending or busy. Count-byte writes never land on the same clock as a transfer completion, except where R4 defines the priority. `byte_ack` is only meaningful while `busy`. The stimulus keeps to these rules by sequencing writes, commands and acknowledges in separate phases, so that each phase settles before the next begins. The one exception is a deliberate burst of acknowledges while idle, which checks that such strobes are ignored.

// File: rtl/dma_tcount_pkg.sv
`timescale 1ns/1ps
package dma_tcount_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_MOVE = 2'd2
   } xfer_state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/dma_tcount_regs.sv
`timescale 1ns/1ps
module dma_tcount_regs
   import dma_tcount_pkg::*;
#(
   parameter int          CNT_BYTES   = 3,
   parameter bit          ID_READBACK = 1'b1,
   parameter logic [7:0]  CHIP_ID     = 8'h3C,
   parameter int          SEL_W       = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [SEL_W-1:0]              wr_sel,
   input  logic [BYTE_W-1:0]             wr_data,
   input  logic                          live_reload,
   input  logic                          live_dec,
   input  logic                          live_clear,
   input  logic [SEL_W-1:0]              rd_sel,
   output logic [BYTE_W-1:0]             rd_data,
   output logic [CNT_BYTES*BYTE_W-1:0]   live_count,
   output logic                          hi_written
);
   localparam int CNT_W = CNT_BYTES * BYTE_W;
   localparam int HI    = CNT_BYTES - 1;

   if (CNT_BYTES < 2) begin : g_bad_bytes
      $error("dma_tcount_regs: CNT_BYTES must be at least 2");
   end
   if ((1 << SEL_W) < CNT_BYTES) begin : g_bad_sel
      $error("dma_tcount_regs: SEL_W too narrow for CNT_BYTES");
   end

   logic [CNT_W-1:0] shadow_vec;
   logic [CNT_W-1:0] live_q;
   logic             hi_wr_q;
   logic [BYTE_W-1:0] rd_byte;

   for (genvar b = 0; b < CNT_BYTES; b++) begin : g_shadow
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (wr_en && (wr_sel == SEL_W'(b))) begin
            byte_q <= wr_data;
         end
      end
      assign shadow_vec[b*BYTE_W +: BYTE_W] = byte_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
      end else if (live_clear) begin
         live_q <= '0;
      end else if (live_reload) begin
         live_q <= shadow_vec;
      end else if (live_dec && (live_q != '0)) begin
         live_q <= live_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_wr_q <= 1'b0;
      end else if (wr_en && (wr_sel == SEL_W'(HI))) begin
         hi_wr_q <= 1'b1;
      end
   end

   always_comb begin
      rd_byte = '0;
      for (int b = 0; b < CNT_BYTES; b++) begin
         if (rd_sel == SEL_W'(b)) begin
            rd_byte = live_q[b*BYTE_W +: BYTE_W];
         end
      end
   end

   if (ID_READBACK) begin : g_id_read
      assign rd_data = ((rd_sel == SEL_W'(HI)) && !hi_wr_q) ? CHIP_ID : rd_byte;
   end else begin : g_plain_read
      assign rd_data = rd_byte;
   end

   assign live_count = live_q;
   assign hi_written = hi_wr_q;

   // R2: reload takes the shadow bytes as they stood before the edge
   p_reload_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (live_reload && !live_clear) |=> (live_q == $past(shadow_vec)));

   // R5: once the high byte has been written, the identifier never returns
   p_hi_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr_q |=> hi_wr_q);

   // R10: decrementing an empty count leaves it empty
   p_live_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (live_dec && !live_reload && !live_clear && (live_q == '0)) |=> (live_q == '0));
endmodule

// File: rtl/dma_tcount_len.sv
`timescale 1ns/1ps
module dma_tcount_len #(
   parameter int CNT_W       = 24,
   parameter int SIZE_W      = 25,
   parameter bit ZERO_IS_MAX = 1'b1,
   parameter int ZERO_CNT    = 65536
) (
   input  logic [CNT_W-1:0]         live_count,
   input  logic signed [SIZE_W-1:0] data_left,
   output logic [CNT_W-1:0]         xfer_len
);
   if (SIZE_W <= CNT_W) begin : g_bad_size
      $error("dma_tcount_len: SIZE_W must exceed CNT_W");
   end
   if (ZERO_IS_MAX && (ZERO_CNT >= (1 << CNT_W))) begin : g_bad_zero
      $error("dma_tcount_len: ZERO_CNT does not fit in CNT_W");
   end

   logic [SIZE_W-1:0] eff_cnt;
   logic [SIZE_W-1:0] mag;
   logic [SIZE_W-1:0] pick;

   if (ZERO_IS_MAX) begin : g_zero_max
      assign eff_cnt = (live_count == '0) ? SIZE_W'(ZERO_CNT)
                                          : {{(SIZE_W-CNT_W){1'b0}}, live_count};
   end else begin : g_zero_plain
      assign eff_cnt = {{(SIZE_W-CNT_W){1'b0}}, live_count};
   end

   assign mag  = data_left[SIZE_W-1] ? SIZE_W'(-data_left) : SIZE_W'(data_left);
   assign pick = (mag < eff_cnt) ? mag : eff_cnt;
   assign xfer_len = pick[CNT_W-1:0];
endmodule

// File: rtl/dma_tcount_seq.sv
`timescale 1ns/1ps
module dma_tcount_seq
   import dma_tcount_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             cmd_wr,
   input  logic             cmd_dma,
   input  logic             cmd_xfer,
   input  logic             dma_en,
   input  logic             byte_ack,
   input  logic [CNT_W-1:0] xfer_len,
   output logic             live_reload,
   output logic             live_dec,
   output logic             live_clear,
   output logic [CNT_W-1:0] remaining,
   output logic             pending,
   output logic             busy,
   output logic             dma_mode,
   output logic             tc,
   output logic             done
);
   xfer_state_e      state_q;
   logic [CNT_W-1:0] rem_q;
   logic             tc_q, done_q, dma_q;
   logic             start, last_ack, zero_start, finish, move_ack;

   assign start      = (state_q == ST_WAIT) && dma_en;
   assign move_ack   = (state_q == ST_MOVE) && byte_ack;
   assign last_ack   = move_ack && (rem_q == CNT_W'(1));
   assign zero_start = start && (xfer_len == '0);
   assign finish     = last_ack || zero_start;

   assign live_reload = cmd_wr && cmd_dma;
   assign live_dec    = move_ack && !last_ack;
   assign live_clear  = finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (cmd_wr && cmd_dma && cmd_xfer) state_q <= ST_WAIT;
            ST_WAIT: if (dma_en) state_q <= (xfer_len == '0) ? ST_IDLE : ST_MOVE;
            ST_MOVE: if (last_ack) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (start) begin
         rem_q <= xfer_len;
      end else if (move_ack) begin
         rem_q <= rem_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q   <= 1'b0;
         done_q <= 1'b0;
         dma_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (finish)              tc_q <= 1'b1;
         else if (start || wr_en) tc_q <= 1'b0;
         if (cmd_wr)              dma_q <= cmd_dma;
      end
   end

   assign remaining = rem_q;
   assign pending   = (state_q == ST_WAIT);
   assign busy      = (state_q == ST_MOVE);
   assign dma_mode  = dma_q;
   assign tc        = tc_q;
   assign done      = done_q;

   // R6: a pending command holds until the enable arrives
   p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !dma_en) |=> pending);

   // R9: an active transfer always has bytes left
   p_busy_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (remaining != '0));

   // R10: without an acknowledge the remaining count holds
   p_rem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !byte_ack) |=> $stable(remaining));

   // R11: completion pulse comes with terminal count and lasts one cycle
   p_done_tc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tc && !busy));
   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/dma_tcount.sv
`timescale 1ns/1ps
module dma_tcount
   import dma_tcount_pkg::*;
#(
   parameter int         CNT_BYTES   = 3,
   parameter bit         ID_READBACK = 1'b1,
   parameter logic [7:0] CHIP_ID     = 8'h3C,
   parameter bit         ZERO_IS_MAX = 1'b1,
   parameter int         ZERO_CNT    = 65536,
   parameter int         SEL_W       = 2,
   parameter int         CNT_W       = CNT_BYTES * 8,
   parameter int         SIZE_W      = CNT_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         wr_sel,
   input  logic [7:0]               wr_data,
   input  logic [SEL_W-1:0]         rd_sel,
   output logic [7:0]               rd_data,
   input  logic                     cmd_wr,
   input  logic                     cmd_dma,
   input  logic                     cmd_xfer,
   input  logic signed [SIZE_W-1:0] data_left,
   input  logic                     dma_en,
   input  logic                     byte_ack,
   output logic [CNT_W-1:0]         live_count,
   output logic [CNT_W-1:0]         remaining,
   output logic                     pending,
   output logic                     busy,
   output logic                     dma_mode,
   output logic                     tc,
   output logic                     done
);
   if (CNT_W != CNT_BYTES * BYTE_W) begin : g_bad_w
      $error("dma_tcount: CNT_W must equal CNT_BYTES*8");
   end

   logic             live_reload, live_dec, live_clear, hi_written;
   logic [CNT_W-1:0] xfer_len;

   dma_tcount_regs #(
      .CNT_BYTES(CNT_BYTES), .ID_READBACK(ID_READBACK),
      .CHIP_ID(CHIP_ID), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .live_reload(live_reload), .live_dec(live_dec),
      .live_clear(live_clear), .rd_sel(rd_sel), .rd_data(rd_data),
      .live_count(live_count), .hi_written(hi_written)
   );

   dma_tcount_len #(
      .CNT_W(CNT_W), .SIZE_W(SIZE_W),
      .ZERO_IS_MAX(ZERO_IS_MAX), .ZERO_CNT(ZERO_CNT)
   ) u_len (
      .live_count(live_count), .data_left(data_left), .xfer_len(xfer_len)
   );

   dma_tcount_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_wr(cmd_wr),
      .cmd_dma(cmd_dma), .cmd_xfer(cmd_xfer), .dma_en(dma_en),
      .byte_ack(byte_ack), .xfer_len(xfer_len), .live_reload(live_reload),
      .live_dec(live_dec), .live_clear(live_clear), .remaining(remaining),
      .pending(pending), .busy(busy), .dma_mode(dma_mode), .tc(tc), .done(done)
   );

   // R4: a count write with no completion on the same edge leaves tc low
   p_tc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !live_clear) |=> !tc);

   // R11: completion leaves the live count empty
   p_done_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (live_count == '0));

   // R6: an enabled pending command leaves the waiting state
   p_start_leaves_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && dma_en) |=> (!pending && (busy || done)));

   // R5: the written flag can only come from a write
   p_hi_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_written) |-> $past(wr_en));
endmodule

// File: tb/dma_tcount_bench.sv
`timescale 1ns/1ps
module dma_tcount_bench;
   localparam int CHIP = 8'h3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic [7:0]  rd_data;
   logic        cmd_wr = 1'b0, cmd_dma = 1'b0, cmd_xfer = 1'b0;
   logic signed [24:0] data_left = '0;
   logic        dma_en = 1'b0, byte_ack = 1'b0;
   logic [23:0] live_count, remaining;
   logic        pending, busy, dma_mode, tc, done;

   int n_vec = 0, n_bad = 0;
   bit finished = 0;

   dma_tcount u_dma_tcount (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .cmd_wr(cmd_wr), .cmd_dma(cmd_dma),
      .cmd_xfer(cmd_xfer), .data_left(data_left), .dma_en(dma_en),
      .byte_ack(byte_ack), .live_count(live_count), .remaining(remaining),
      .pending(pending), .busy(busy), .dma_mode(dma_mode), .tc(tc), .done(done)
   );

   always #10 clk = ~clk;

   // behavioural reference model
   int  m_sh [3];
   int  m_live, m_rem;
   bit  m_hiw, m_pend, m_act, m_tc, m_done, m_dma;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) m_sh[i] = 0;
         m_live = 0; m_rem = 0; m_hiw = 0; m_pend = 0; m_act = 0;
         m_tc = 0; m_done = 0; m_dma = 0;
      end else begin
         int o_live, o_rem, shv, eff, mag, len;
         bit o_pend, o_act;
         o_live = m_live; o_rem = m_rem; o_pend = m_pend; o_act = m_act;
         shv = m_sh[0] | (m_sh[1] << 8) | (m_sh[2] << 16);
         m_done = 0;
         if (wr_en) begin
            if (wr_sel < 3) m_sh[wr_sel] = wr_data;
            if (wr_sel == 2) m_hiw = 1;
            m_tc = 0;
         end
         if (cmd_wr) begin
            m_dma = cmd_dma;
            if (cmd_dma) m_live = shv;
            if (cmd_dma && cmd_xfer && !o_pend && !o_act) m_pend = 1;
         end
         if (o_pend && dma_en) begin
            eff = (o_live == 0) ? 65536 : o_live;
            mag = (data_left < 0) ? -int'(data_left) : int'(data_left);
            len = (mag < eff) ? mag : eff;
            m_pend = 0; m_tc = 0; m_rem = len;
            if (len == 0) begin
               m_tc = 1; m_live = 0; m_done = 1;
            end else m_act = 1;
         end else if (o_act && byte_ack) begin
            m_rem = o_rem - 1;
            if (o_rem == 1) begin
               m_act = 0; m_tc = 1; m_live = 0; m_done = 1;
            end else if (o_live != 0) m_live = o_live - 1;
         end
      end
   end

   function automatic int model_rd();
      if (rd_sel > 2) return 0;
      if (rd_sel == 2 && !m_hiw) return CHIP;
      return (m_live >> (8 * rd_sel)) & 255;
   endfunction

   task automatic check(string tag, longint act, longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R1 live_count", live_count, m_live);
      check("R5 rd_data", rd_data, model_rd());
      check("R8 remaining", remaining, m_rem);
      check("R6 pending", pending, m_pend);
      check("R9 busy", busy, m_act);
      check("R2 dma_mode", dma_mode, m_dma);
      check("R4 tc", tc, m_tc);
      check("R11 done", done, m_done);
   endtask

   task automatic tick();
      @(posedge clk); #5;
      compare_all();
   endtask

   task automatic wr_byte(int sel, int val);
      wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(val);
      tick();
      wr_en = 0;
   endtask

   task automatic issue(bit dma, bit xfer);
      cmd_wr = 1; cmd_dma = dma; cmd_xfer = xfer;
      tick();
      cmd_wr = 0; cmd_dma = 0; cmd_xfer = 0;
   endtask

   task automatic acks(int n);
      byte_ack = 1;
      for (int i = 0; i < n; i++) tick();
      byte_ack = 0;
   endtask

   task automatic load(int val);
      wr_byte(0, val & 255);
      wr_byte(1, (val >> 8) & 255);
      wr_byte(2, (val >> 16) & 255);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #5 rst_n = 1;
      tick();
      // R13 reset state
      check("R13 tc after reset", tc, 0);
      check("R13 live after reset", live_count, 0);
      check("R13 busy after reset", busy, 0);
      // R5 identifier before high write
      rd_sel = 2; tick();
      check("R5 chip id readback", rd_data, CHIP);
      // R3 shadow writes leave live alone
      wr_byte(0, 8'h34); wr_byte(1, 8'h12);
      check("R3 live unchanged by shadow write", live_count, 0);
      check("R5 id persists before high write", rd_data, CHIP);
      wr_byte(2, 8'h00);
      check("R5 live high after write", rd_data, 0);
      // R2 reload, R1 byte reads
      issue(1, 0);
      check("R2 reload", live_count, 24'h001234);
      check("R2 dma_mode set", dma_mode, 1);
      rd_sel = 0; tick(); check("R1 low byte", rd_data, 8'h34);
      rd_sel = 1; tick(); check("R1 mid byte", rd_data, 8'h12);
      rd_sel = 3; tick(); check("R1 unused select", rd_data, 0);
      issue(0, 0);
      check("R2 dma_mode cleared", dma_mode, 0);
      check("R2 live kept", live_count, 24'h001234);
      // R6 non-DMA transfer command ignored
      issue(0, 1); tick();
      check("R6 non-dma xfer ignored", pending, 0);
      // transfer of 5 with data_left 100, waiting for enable
      load(5); data_left = 100;
      issue(1, 1);
      repeat (3) tick();
      check("R6 held pending", pending, 1);
      dma_en = 1; tick();
      check("R9 busy at start", busy, 1);
      check("R8 len from count", remaining, 5);
      acks(2); tick(); acks(2);
      check("R10 decrement", remaining, 1);
      acks(1);
      check("R11 tc at end", tc, 1);
      check("R11 done pulse", done, 1);
      check("R11 live zeroed", live_count, 0);
      tick();
      check("R11 done one cycle", done, 0);
      acks(2);
      check("R10 idle ack ignored", remaining, 0);
      wr_byte(0, 9);
      check("R4 write clears tc", tc, 0);
      // R8 toward device, smaller size
      load(24'h010203); data_left = -3;
      issue(1, 1); tick();
      check("R8 negative size", remaining, 3);
      check("R9 tc cleared at start", tc, 0);
      acks(1);
      check("R10 live dec", live_count, 24'h010202);
      acks(2);
      check("R11 big count end", live_count, 0);
      // R12 zero length
      load(7); data_left = 0;
      issue(1, 1); tick();
      check("R12 immediate done", done, 1);
      check("R12 never busy", busy, 0);
      // R7 zero count means 65536
      load(0); data_left = 70000;
      issue(1, 1); tick();
      check("R7 zero count as 65536", remaining, 65536);
      acks(65535);
      check("R10 live saturates", live_count, 0);
      check("R7 one left", remaining, 1);
      acks(1);
      check("R11 end of long transfer", tc, 1);
      tick();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule